// File: doc/BRIEF.md
# Dual-Channel Register-Mapped GPIO Controller

This block is a general-purpose I/O peripheral with one or two pin channels, each from 1 to 32 bits wide. For each channel a host can write an output value and a per-pin direction, and read back the pin state. All access goes through a plain word-wide register bus: a write strobe, a byte offset, write data, and combinational read data. Pad buffers are not part of the block. It drives an output vector and an output-enable vector for each channel and takes in an input vector.

Input pins pass through a two-stage synchronizer. Any change on a channel's input-direction pins sets that channel's sticky status bit. A host clears a status bit by writing a one to it. The status bits are masked by per-channel enables and then by one global enable before they reach the single interrupt line. Edge polarity and the search for which pin moved are left to software: it reads the data register and compares it with the value it saw last time.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset every direction bit is 1, meaning input, so every output-enable is 0. Output values are 0, all status, enable and global-enable bits are 0, and irq is low. The direction and output reset values are parameters.
- R2: Channel 1 has its output value at offset 0x000 and its direction at offset 0x004. A written value appears on a_out one cycle later. a_oe is the bitwise inverse of the direction register, so bit=1 means input and bit=0 means drive.
- R3: Reading a data offset returns the synchronized pin level for input-direction bits and the held output value for output-direction bits. A pin change is visible in the read value after two clock edges, not after one.
- R4: Channel 2 uses offsets 0x008 for data and 0x00C for direction, with the same meaning as channel 1. Writes to one channel leave the other channel's pins untouched.
- R5: A change on any input-direction pin of channel 1 sets status bit 0 at offset 0x120. A change on channel 2 sets bit 1. Changes on output-direction pins set nothing. Status bits stay set until they are cleared.
- R6: Writing offset 0x120 clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged. A change event in the same cycle keeps the bit set.
- R7: irq is high exactly when global-enable bit 31 at offset 0x11C is 1 and status AND the per-channel enable at offset 0x128 (bit 0 for channel 1, bit 1 for channel 2) is nonzero.
- R8: Unmapped offsets read 0 and writes to them change nothing. Register bits above a channel's width read 0. Offset 0x11C reads only bit 31 and offset 0x128 reads only bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| a_in | input | A_WIDTH | Channel 1 pin levels |
| a_out | output | A_WIDTH | Channel 1 output values |
| a_oe | output | A_WIDTH | Channel 1 output enables |
| b_in | input | B_WIDTH | Channel 2 pin levels |
| b_out | output | B_WIDTH | Channel 2 output values |
| b_oe | output | B_WIDTH | Channel 2 output enables |
| irq | output | 1 | Interrupt request |

## Verification
The data-read path is tried with a mixed direction mask and an input pattern that differs from the held output value. This tells apart a read that selects per bit from one that returns only pins or only the register. The interrupt path is tried with a toggle on an input pin, a toggle on an output pin, and a toggle on the second channel. These show whether status is qualified by direction and routed to the correct bit. Enable and global-enable are changed one at a time around a set status, and clears are written with the other bit's mask, to separate the gate terms and the write-one-to-clear behaviour. A 12-bit second channel exposes any leak into the bits above its width.

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank #(
  parameter int          A_WIDTH    = 32,
  parameter int          B_WIDTH    = 32,
  parameter bit          DUAL       = 1'b1,
  parameter logic [31:0] A_OUT_INIT = 32'h0,
  parameter logic [31:0] A_DIR_INIT = 32'hFFFF_FFFF,
  parameter logic [31:0] B_OUT_INIT = 32'h0,
  parameter logic [31:0] B_DIR_INIT = 32'hFFFF_FFFF,
  parameter int          AW         = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [A_WIDTH-1:0] a_in,
  output logic [A_WIDTH-1:0] a_out,
  output logic [A_WIDTH-1:0] a_oe,
  input  logic [B_WIDTH-1:0] b_in,
  output logic [B_WIDTH-1:0] b_out,
  output logic [B_WIDTH-1:0] b_oe,
  output logic               irq
);
  localparam logic [AW-1:0] OFS_A_DAT = AW'(9'h000);
  localparam logic [AW-1:0] OFS_A_DIR = AW'(9'h004);
  localparam logic [AW-1:0] OFS_B_DAT = AW'(9'h008);
  localparam logic [AW-1:0] OFS_B_DIR = AW'(9'h00C);
  localparam logic [AW-1:0] OFS_GIE   = AW'(9'h11C);
  localparam logic [AW-1:0] OFS_STS   = AW'(9'h120);
  localparam logic [AW-1:0] OFS_IEN   = AW'(9'h128);

  logic [A_WIDTH-1:0] out_a, dir_a, a_s1, a_s2, a_s3;
  logic [B_WIDTH-1:0] out_b, dir_b, b_s2, b_s3;
  logic [1:0]         sts, ien, warm;
  logic               gie, chg_a, chg_b;

  wire wr_gie = bus_wr && bus_addr == OFS_GIE;
  wire wr_sts = bus_wr && bus_addr == OFS_STS;
  wire wr_ien = bus_wr && bus_addr == OFS_IEN;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_s1 <= '0; a_s2 <= '0; a_s3 <= '0;
      out_a <= A_OUT_INIT[A_WIDTH-1:0];
      dir_a <= A_DIR_INIT[A_WIDTH-1:0];
    end else begin
      a_s1 <= a_in; a_s2 <= a_s1; a_s3 <= a_s2;
      if (bus_wr && bus_addr == OFS_A_DAT) out_a <= bus_wdata[A_WIDTH-1:0];
      if (bus_wr && bus_addr == OFS_A_DIR) dir_a <= bus_wdata[A_WIDTH-1:0];
    end

  assign chg_a = (warm == 2'd3) && |((a_s2 ^ a_s3) & dir_a);
  assign a_out = out_a;
  assign a_oe  = ~dir_a;

  generate
    if (DUAL) begin : g_chan_b
      logic [B_WIDTH-1:0] b_s1;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          b_s1 <= '0; b_s2 <= '0; b_s3 <= '0;
          out_b <= B_OUT_INIT[B_WIDTH-1:0];
          dir_b <= B_DIR_INIT[B_WIDTH-1:0];
        end else begin
          b_s1 <= b_in; b_s2 <= b_s1; b_s3 <= b_s2;
          if (bus_wr && bus_addr == OFS_B_DAT) out_b <= bus_wdata[B_WIDTH-1:0];
          if (bus_wr && bus_addr == OFS_B_DIR) dir_b <= bus_wdata[B_WIDTH-1:0];
        end
      assign chg_b = (warm == 2'd3) && |((b_s2 ^ b_s3) & dir_b);
      assign b_oe  = ~dir_b;
    end else begin : g_no_b
      assign b_s2  = '0;
      assign b_s3  = '0;
      assign out_b = '0;
      assign dir_b = '1;
      assign chg_b = 1'b0;
      assign b_oe  = '0;
    end
  endgenerate
  assign b_out = out_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sts <= '0; ien <= '0; gie <= 1'b0;
    end else begin
      sts <= (sts & ~({2{wr_sts}} & bus_wdata[1:0])) | {chg_b, chg_a};
      if (wr_ien) ien <= {bus_wdata[1] & DUAL, bus_wdata[0]};
      if (wr_gie) gie <= bus_wdata[31];
    end

  assign irq = gie && |(sts & ien);

  wire [A_WIDTH-1:0] a_rd = (dir_a & a_s2) | (~dir_a & out_a);
  wire [B_WIDTH-1:0] b_rd = (dir_b & b_s2) | (~dir_b & out_b);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_A_DAT: bus_rdata = 32'(a_rd);
      OFS_A_DIR: bus_rdata = 32'(dir_a);
      OFS_B_DAT: if (DUAL) bus_rdata = 32'(b_rd);
      OFS_B_DIR: if (DUAL) bus_rdata = 32'(dir_b);
      OFS_GIE:   bus_rdata = {gie, 31'b0};
      OFS_STS:   bus_rdata = {30'b0, sts};
      OFS_IEN:   bus_rdata = {30'b0, ien};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

module gpio_dual_bank_chk #(
  parameter int          A_WIDTH    = 32,
  parameter int          AW         = 9,
  parameter logic [31:0] A_OUT_INIT = 32'h0,
  parameter logic [31:0] A_DIR_INIT = 32'hFFFF_FFFF
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [AW-1:0]      bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [A_WIDTH-1:0] a_out,
  input logic [A_WIDTH-1:0] a_oe,
  input logic               irq,
  input logic               gie,
  input logic [1:0]         sts,
  input logic               chg_a
);
  // R1
  rst_dflt_chk: assert property (@(posedge clk)
    !rst_n |=> (a_oe == ~A_DIR_INIT[A_WIDTH-1:0]) && (a_out == A_OUT_INIT[A_WIDTH-1:0]) && !irq);
  // R2
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(9'h004) |=> a_oe == ~$past(bus_wdata[A_WIDTH-1:0]));
  // R4
  chan_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(9'h008) |=> $stable(a_out));
  // R5
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts[0] && !(bus_wr && bus_addr == AW'(9'h120) && bus_wdata[0]) |=> sts[0]);
  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(9'h120) && bus_wdata[0] && !chg_a |=> !sts[0]);
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);
endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(
  .A_WIDTH(A_WIDTH), .AW(AW), .A_OUT_INIT(A_OUT_INIT), .A_DIR_INIT(A_DIR_INIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .a_out(a_out), .a_oe(a_oe), .irq(irq),
  .gie(gie), .sts(sts), .chg_a(chg_a)
);

// File: tb/gpio_dual_bank_bench.sv
`timescale 1ns/1ps
module gpio_dual_bank_bench;
  localparam int AWD = 32;
  localparam int BWD = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic [8:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [AWD-1:0]  a_in = '0;
  logic [AWD-1:0]  a_out, a_oe;
  logic [BWD-1:0]  b_in = '0;
  logic [BWD-1:0]  b_out, b_oe;
  logic            irq;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gpio_dual_bank #(.A_WIDTH(AWD), .B_WIDTH(BWD), .DUAL(1'b1)) u_gpio_dual_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .a_in(a_in), .a_out(a_out),
    .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 a_oe", 32'(a_oe), 32'h0);
    chk("R1 a_out", 32'(a_out), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(9'h004, v); chk("R1 dir a", v, 32'hFFFF_FFFF);
    rd(9'h00C, v); chk("R1 R8 dir b width", v, 32'h0000_0FFF);
    rd(9'h120, v); chk("R1 status", v, 32'h0);
  endtask

  task automatic t_output;
    logic [31:0] v;
    wr(9'h004, 32'hFFFF_0000);
    chk("R2 oe", 32'(a_oe), 32'h0000_FFFF);
    wr(9'h000, 32'h1234_ABCD);
    chk("R2 out", 32'(a_out), 32'h1234_ABCD);
    a_in = 32'hA5A5_5555;
    repeat (3) @(negedge clk);
    rd(9'h000, v); chk("R3 mixed read", v, 32'hA5A5_ABCD);
  endtask

  task automatic t_sync;
    logic [31:0] v;
    wr(9'h120, 32'h3);
    @(negedge clk);
    a_in[31] = 1'b0;
    @(negedge clk);
    rd(9'h000, v); chk("R3 one edge old", v, 32'hA5A5_ABCD);
    @(negedge clk);
    rd(9'h000, v); chk("R3 two edges new", v, 32'h25A5_ABCD);
  endtask

  task automatic t_chan2;
    logic [31:0] v;
    wr(9'h008, 32'hFFFF_FFFF);
    chk("R4 b out", 32'(b_out), 32'h0000_0FFF);
    chk("R4 a untouched", 32'(a_out), 32'h1234_ABCD);
    wr(9'h00C, 32'h0000_00F0);
    chk("R4 b oe", 32'(b_oe), 32'h0000_0F0F);
    repeat (2) @(negedge clk);
    rd(9'h008, v); chk("R4 R8 b read", v, 32'h0000_0F0F);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    wr(9'h120, 32'h3);
    wr(9'h128, 32'h1);
    a_in[20] = ~a_in[20];
    repeat (4) @(negedge clk);
    rd(9'h120, v); chk("R5 status ch1", v, 32'h1);
    chk("R7 no gie", 32'(irq), 32'h0);
    wr(9'h11C, 32'h8000_0000);
    chk("R7 irq on", 32'(irq), 32'h1);
    wr(9'h128, 32'h2);
    chk("R7 ien off", 32'(irq), 32'h0);
    wr(9'h128, 32'h1);
    chk("R7 irq back", 32'(irq), 32'h1);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(9'h120, 32'h2);
    rd(9'h120, v); chk("R6 zero write keeps", v, 32'h1);
    wr(9'h120, 32'h1);
    rd(9'h120, v); chk("R6 one write clears", v, 32'h0);
    chk("R7 irq drops", 32'(irq), 32'h0);
    a_in[3] = ~a_in[3];
    repeat (4) @(negedge clk);
    rd(9'h120, v); chk("R5 output pin ignored", v, 32'h0);
    b_in[5] = 1'b1;
    repeat (4) @(negedge clk);
    rd(9'h120, v); chk("R5 status ch2", v, 32'h2);
    chk("R7 ch2 masked", 32'(irq), 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(9'h010, 32'hFFFF_FFFF);
    rd(9'h010, v); chk("R8 unmapped read", v, 32'h0);
    chk("R8 unmapped write", 32'(a_out), 32'h1234_ABCD);
    wr(9'h124, 32'hFFFF_FFFF);
    rd(9'h124, v); chk("R8 gap read", v, 32'h0);
    wr(9'h11C, 32'hFFFF_FFFF);
    rd(9'h11C, v); chk("R8 gie bits", v, 32'h8000_0000);
    wr(9'h128, 32'hFFFF_FFFF);
    rd(9'h128, v); chk("R8 ien bits", v, 32'h3);
    chk("R7 ch2 enabled", 32'(irq), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_output;
    t_sync;
    t_chan2;
    t_irq;
    t_w1c;
    t_unmapped;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule